// File: doc/BRIEF.md
# Fractional Frequency Clock Generator Bank

This block holds a bank of independent programmable clock sources, all running from the core clock. Each source is a phase accumulator: on every core cycle it adds its programmed increment N, and the top bit of the sum becomes that source's clock output. With an accumulator of 32 bits, the mean output frequency is the core frequency times N over 2^32. Periods that do not divide evenly are spread across cycles, so the output is a fractional-rate square wave with one cycle of jitter.

Software programs each source through a write port and reads it back through a separate read port. Each source has one register, placed at 8-byte steps in the byte address space. An increment of zero parks a source. Increments above half range would push the output past half the core rate, so they are clamped to the largest legal value on write. The outputs are exported as a bus for a pin multiplexer outside this block to select from.

Each source is a two-state machine. In GEN_HALT the accumulator is frozen and the output is held low. In GEN_RUN it accumulates every cycle. The machine moves from GEN_HALT to GEN_RUN on a write of a non-zero increment (after clamping). It moves from GEN_RUN to GEN_HALT on a write of zero. Any other write keeps the current state.

Top module: `clkgen_bank`

## Requirements
- R1: After reset every output is low, every increment register reads 0 and every source is in GEN_HALT with its accumulator at 0.
- R2: A write with `wr_en` high stores `wr_data` into the source whose index is byte address bits [4:3]. Bits [2:0] are ignored. `rd_data` returns the stored increment of the source picked by `rd_addr` bits [4:3] in the same cycle.
- R3: In GEN_RUN the accumulator gains N, modulo 2^32, on each core clock edge. `gen_clk[i]` is registered and equals bit 31 of the sum that the same edge produces.
- R4: Over a window of W cycles, a source with N = 2^28 started from phase 0 shows W*N/2^32 rising edges on its output (16 in 256 cycles).
- R5: Writing N = 0 puts the source in GEN_HALT. Its output is low from the next edge and its accumulator holds. A later non-zero write resumes accumulation from the held phase.
- R6: A written value above 2^31-1 (bit 31 set) is stored as 2^31-1, and reads back as 0x7FFF_FFFF.
- R7: A write to one source leaves the increment, phase and output of every other source unchanged.
- R8: A new non-zero increment written to a running source is used from the next edge on, without resetting its phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the increment registers |
| wr_addr | input | 5 | Byte address of the write; bits [4:3] pick the source |
| wr_data | input | 32 | Increment value to store |
| rd_addr | input | 5 | Byte address of the read; bits [4:3] pick the source |
| rd_data | output | 32 | Stored increment of the addressed source |
| gen_clk | output | 4 | Generated clock of each source |

## Verification
The bench builds the bank with its default parameters: four sources and 32-bit accumulators. With this width, increments near 2^31 toggle an output almost every cycle, and a power-of-two increment such as 2^28 gives an exact 16-cycle period. Rate, wrap-around and the half-range clamp can therefore all be seen within a few hundred cycles. A cycle-level reference accumulator in the bench is compared with every output on every cycle, across halts, restarts and retunes.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic {
        GEN_HALT = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

endpackage

// File: rtl/clkgen_decode.sv
module clkgen_decode #(
    parameter int NUM_GEN     = 4,
    parameter int STRIDE_LOG2 = 3,
    parameter int ADDR_W      = 5
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    output logic [NUM_GEN-1:0] hit_o
);

    localparam int IDX_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

    logic [IDX_W-1:0] idx;
    assign idx = wr_addr[STRIDE_LOG2 +: IDX_W];

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_hit
        assign hit_o[g] = wr_en && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/clkgen_channel.sv
module clkgen_channel
    import clkgen_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    output logic [ACC_W-1:0] inc_o,
    output logic             clk_o
);

    localparam logic [ACC_W-1:0] INC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

    gen_state_e       state_q, state_d;
    logic [ACC_W-1:0] inc_q, inc_d, inc_clamped;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic             out_q, out_d;

    assign inc_clamped = load_val[ACC_W-1] ? INC_MAX : load_val;

    // transitions
    always_comb begin
        state_d = state_q;
        inc_d   = load ? inc_clamped : inc_q;
        unique case (state_q)
            GEN_HALT: if (load && (inc_clamped != '0)) state_d = GEN_RUN;
            GEN_RUN:  if (load && (inc_clamped == '0)) state_d = GEN_HALT;
            default:  state_d = GEN_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GEN_HALT;
            inc_q   <= '0;
        end else begin
            state_q <= state_d;
            inc_q   <= inc_d;
        end
    end

    // per-state outputs
    always_comb begin
        acc_d = acc_q;
        out_d = 1'b0;
        unique case (state_q)
            GEN_HALT: out_d = 1'b0;
            GEN_RUN: begin
                acc_d = acc_q + inc_q;
                out_d = acc_d[ACC_W-1];
            end
            default: out_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            out_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            out_q <= out_d;
        end
    end

    assign inc_o = inc_q;
    assign clk_o = out_q;

    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_HALT) |=> !clk_o); // R5
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_HALT) |=> $stable(acc_q)); // R5
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_RUN) |=> (acc_q == $past(acc_q) + $past(inc_q))); // R3
    AST_OUT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_RUN) |=> (clk_o == acc_q[ACC_W-1])); // R3
    AST_INC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_q[ACC_W-1]); // R6
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(inc_q)); // R7

endmodule

// File: rtl/clkgen_bank.sv
module clkgen_bank
    import clkgen_pkg::*;
#(
    parameter int  NUM_GEN     = 4,
    parameter int  ACC_W       = 32,
    parameter int  STRIDE_LOG2 = 3,
    localparam int IDX_W       = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1,
    localparam int ADDR_W      = STRIDE_LOG2 + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [ACC_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [ACC_W-1:0]   rd_data,
    output logic [NUM_GEN-1:0] gen_clk
);

    logic [NUM_GEN-1:0] hit;
    logic [ACC_W-1:0]   inc_all [NUM_GEN];
    logic [IDX_W-1:0]   rd_idx;

    clkgen_decode #(
        .NUM_GEN     (NUM_GEN),
        .STRIDE_LOG2 (STRIDE_LOG2),
        .ADDR_W      (ADDR_W)
    ) i_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .hit_o   (hit)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        clkgen_channel #(
            .ACC_W (ACC_W)
        ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (hit[g]),
            .load_val (wr_data),
            .inc_o    (inc_all[g]),
            .clk_o    (gen_clk[g])
        );
    end

    assign rd_idx = rd_addr[STRIDE_LOG2 +: IDX_W];

    always_comb begin
        rd_data = '0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (rd_idx == IDX_W'(g)) rd_data = inc_all[g];
        end
    end

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R7
    AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> wr_en); // R2

endmodule

// File: tb/test_clkgen_bank.sv
module test_clkgen_bank;

    localparam int NG = 4;
    localparam int AW = 5;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [7:0]    cyc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'h00, 32'h1000_0000, 8'd40},  // gen0, period 16
        '{5'h10, 32'h7FFF_FFFF, 8'd20},  // gen2, top legal value
        '{5'h1D, 32'h0123_4567, 8'd30},  // gen3, low address bits ignored
        '{5'h00, 32'h0000_0000, 8'd20},  // gen0 halted
        '{5'h00, 32'h0C00_0000, 8'd40},  // gen0 resumes from held phase
        '{5'h12, 32'hFFFF_FFFF, 8'd20}   // gen2 clamped
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [NG-1:0] gen_clk;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    clkgen_bank i_clkgen_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .gen_clk (gen_clk)
    );

    function automatic logic [DW-1:0] clamp(input logic [DW-1:0] d);
        return d[DW-1] ? 32'h7FFF_FFFF : d;
    endfunction

    function automatic logic top_of_sum(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] s;
        s = a + b;
        return s[DW-1];
    endfunction

    // reference model from the requirements
    logic [DW-1:0] m_acc [NG];
    logic [DW-1:0] m_inc [NG];
    logic [NG-1:0] m_out;

    always @(posedge clk) begin
        for (int g = 0; g < NG; g++) begin
            if (!rst_n) begin
                m_acc[g] <= '0;
                m_inc[g] <= '0;
                m_out[g] <= 1'b0;
            end else begin
                if (m_inc[g] != '0) begin
                    m_acc[g] <= m_acc[g] + m_inc[g];
                    m_out[g] <= top_of_sum(m_acc[g], m_inc[g]);
                end else begin
                    m_out[g] <= 1'b0;
                end
                if (wr_en && (int'(wr_addr[4:3]) == g)) m_inc[g] <= clamp(wr_data);
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        rd_addr = a;
        #1;
        check(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(gen_clk === m_out, req, DW'(gen_clk), DW'(m_out));
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int rises;
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(gen_clk === '0, "R1", DW'(gen_clk), '0);
        for (int g = 0; g < NG; g++) rd_check(AW'(g * 8), '0, "R1");
        run(5, "R1");

        // R4: rate of a fresh source at N = 2^28
        wr(5'h08, 32'h1000_0000);
        rises = 0;
        prev  = gen_clk[1];
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (gen_clk[1] && !prev) rises++;
            prev = gen_clk[1];
        end
        check(rises == 16, "R4", DW'(rises), 32'd16);

        // vector table: R3 on outputs, R2 on readback
        foreach (VECS[v]) begin
            wr(VECS[v].addr, VECS[v].data);
            rd_check(VECS[v].addr, clamp(VECS[v].data), "R2");
            run(int'(VECS[v].cyc), "R3");
        end

        // R5: halt holds output low, resume continues held phase
        wr(5'h00, 32'h0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check(gen_clk[0] === 1'b0, "R5", DW'(gen_clk[0]), 32'h0);
        end
        wr(5'h04, 32'h2345_6789);
        run(40, "R5");

        // R8: retune a running source without phase reset
        wr(5'h18, 32'h3000_0001);
        run(30, "R8");
        wr(5'h18, 32'h0800_0000);
        run(30, "R8");

        // R6: clamp of out-of-range values
        wr(5'h10, 32'h8000_0000);
        rd_check(5'h10, 32'h7FFF_FFFF, "R6");
        run(10, "R6");
        wr(5'h10, 32'hFFFF_FFFF);
        rd_check(5'h10, 32'h7FFF_FFFF, "R6");

        // R7: write to one source leaves the others alone
        wr(5'h08, 32'h0000_0000);
        rd_check(5'h00, 32'h2345_6789, "R7");
        rd_check(5'h10, 32'h7FFF_FFFF, "R7");
        rd_check(5'h18, 32'h0800_0000, "R7");
        run(40, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule